// File: doc/BRIEF.md
# Presettable Down Counter with Decade or Binary Stages

This block is an eight-stage synchronous down counter whose count drops by one on every rising clock edge while its active-low count-enable input is low. A parameter chooses between a single 8-bit binary count and two chained 4-bit decimal digits. In decimal mode the low digit borrows from the high digit when it wraps from 0 to 9. The counter can be loaded from an 8-bit jam word in two ways. The synchronous path loads on the next rising edge. The asynchronous path loads at once, without waiting for a clock.

An active-low clear forces the count to its largest value at once: 255 in binary mode and 99 in decimal mode. The active-low zero-detect output goes low for the whole clock period in which the count is zero and counting is enabled. A free-running counter therefore divides the clock by 256 or by 100. Because the zero-detect output and the count-enable input have the same polarity and timing, one counter's zero-detect output can drive the next counter's enable to build a longer chain.

All control inputs are active-low. Their precedence is fixed: clear, then asynchronous load, then synchronous load, then counting.

Top module: `preset_down_counter`

## Requirements
- R1: While `clear_n` is low, `count_q` is the maximum code at once and stays there, whatever the other inputs and the clock do. The maximum code is 8'hFF in binary mode and 8'h99 in decimal mode.
- R2: When every control input is high except `cnt_en_n`, which is low, each rising clock edge lowers the count by one. In binary mode 8'h00 is followed by 8'hFF.
- R3: When `cnt_en_n`, `load_sync_n`, `load_async_n` and `clear_n` are all high, `count_q` holds its value across clock edges and ignores `jam_word`.
- R4: When `load_sync_n` is low and `load_async_n` and `clear_n` are high, `count_q` takes `jam_word` on the next rising edge, whatever the level of `cnt_en_n`.
- R5: While `load_async_n` is low and `clear_n` is high, `count_q` equals `jam_word` with no clock edge needed. Rising edges change nothing in this state, whatever the levels of `load_sync_n` and `cnt_en_n`.
- R6: `clear_n` low takes priority over `load_async_n` low, so the maximum code wins.
- R7: `zero_n` is low exactly when `count_q` is zero and `cnt_en_n` is low. With `cnt_en_n` high, `zero_n` stays high even at zero count.
- R8: A counter that runs with only `cnt_en_n` low goes from zero to the maximum code on the next edge, so `zero_n` is low for one clock period in each cycle. The cycle is 256 clocks in binary mode and 100 clocks in decimal mode.
- R9: In decimal mode `jam_word[3:0]` is the low digit and `jam_word[7:4]` is the high digit. Each decrement follows decimal order: a low digit of 0 becomes 9 and lowers the high digit, and a count of 8'h00 becomes 8'h99.
- R10: In decimal mode a loaded digit above 9 is kept as given. On each decrement that reaches it, the digit drops by one and no borrow goes to the other digit. A low digit of 0 still borrows from a high digit above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clear_n | input | 1 | Asynchronous clear to maximum code, active low |
| load_async_n | input | 1 | Asynchronous load of `jam_word`, active low |
| load_sync_n | input | 1 | Synchronous load of `jam_word`, active low |
| cnt_en_n | input | 1 | Count enable / carry in, active low |
| jam_word | input | 8 | Preset value (two decimal digits in decimal mode) |
| zero_n | output | 1 | Zero detect / carry out, active low |
| count_q | output | 8 | Present count |

## Verification
The bench loads every one of the 256 jam values into a binary and a decimal instance and steps each one once. This covers the nonsensical digits above 9 as well. A design with a wrong borrow rule would then give a wrong successor for some pattern, and a design that applied the enable during a synchronous load would not take the jam word. A full-cycle run checks that zero is followed by the maximum code and that the zero flag is low for a single period. A design that wrapped to zero, or that let the zero flag ignore the enable, would miss a count or pulse at the wrong time. The asynchronous load and clear are checked between clock edges and against each other, which catches a design that waits for the clock or has the two priorities swapped.

// File: rtl/pdc_pkg.sv
// Package: shared mode type, digit width and the maximum-code function
// for the presettable down counter. It assumes digits of four bits.
package pdc_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } count_mode_e;

    // Largest code: every digit at 9 in decade mode, all ones in binary mode.
    function automatic logic [63:0] max_code(count_mode_e mode, int num_digits);
        logic [63:0] acc;
        acc = '0;
        for (int i = 0; i < num_digits; i++) begin
            acc = (acc << DIGIT_W) | ((mode == MODE_DECADE) ? 64'd9 : 64'd15);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pdc_digit.sv
// One decimal digit of the decrement network. When a borrow comes in, the
// digit steps down: 0 becomes 9 and sends a borrow on, and any other value
// (including codes above 9) drops by one without a borrow.
// Assumes DIGIT_W bits per digit.
module pdc_digit
    import pdc_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               borrow_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               borrow_o
);

    // Purpose: next value of this digit and the borrow it sends upward.
    always_comb begin
        digit_o  = digit_i;
        borrow_o = 1'b0;
        if (borrow_i) begin
            if (digit_i == '0) begin
                digit_o  = DIGIT_W'(9);
                borrow_o = 1'b1;
            end else begin
                digit_o  = digit_i - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdc_step.sv
// Decrement network. It returns count minus one in the chosen mode. Binary
// mode uses a plain subtractor. Decade mode chains digit stages, with the
// borrow going from the low digit to the high one. Purely combinational.
module pdc_step
    import pdc_pkg::*;
#(
    parameter count_mode_e MODE       = MODE_BINARY,
    parameter int          NUM_DIGITS = 2,
    localparam int         WIDTH      = NUM_DIGITS * DIGIT_W
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);

    generate
        if (MODE == MODE_BINARY) begin : g_binary
            // Purpose: modulo-2^WIDTH decrement.
            assign nxt_o = cur_i - 1'b1;
        end else begin : g_decade
            logic [NUM_DIGITS:0] borrow;
            assign borrow[0] = 1'b1;
            for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
                pdc_digit u_digit (
                    .digit_i  (cur_i[d*DIGIT_W +: DIGIT_W]),
                    .borrow_i (borrow[d]),
                    .digit_o  (nxt_o[d*DIGIT_W +: DIGIT_W]),
                    .borrow_o (borrow[d+1])
                );
            end
        end
    endgenerate

endmodule

// File: rtl/pdc_state.sv
// Count register with the fixed control precedence: asynchronous clear to
// the maximum code, then asynchronous load, then synchronous load, then
// enabled decrement. Both asynchronous controls are level overrides.
// Assumes jam_i is steady while the asynchronous load is held low.
module pdc_state #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] MAX_CNT = '1
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_async_n,
    input  logic             load_sync_n,
    input  logic             cnt_en_n,
    input  logic [WIDTH-1:0] jam_i,
    input  logic [WIDTH-1:0] nxt_i,
    output logic [WIDTH-1:0] count_o
);

    // Purpose: hold the count and apply clear, loads and decrement by priority.
    always_ff @(posedge clk or negedge clear_n or negedge load_async_n) begin
        if (!clear_n) begin
            count_o <= MAX_CNT;
        end else if (!load_async_n) begin
            count_o <= jam_i;
        end else if (!load_sync_n) begin
            count_o <= jam_i;
        end else if (!cnt_en_n) begin
            count_o <= nxt_i;
        end
    end

endmodule

// File: rtl/pdc_zero.sv
// Zero detect / carry out. It is low for the whole period in which the count
// is zero and the count enable is low, so a following stage can use it as
// its own enable.
module pdc_zero #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count_i,
    input  logic             cnt_en_n,
    output logic             zero_n
);

    // Purpose: active-low flag for zero count gated by the enable.
    always_comb begin
        zero_n = ~((count_i == '0) & ~cnt_en_n);
    end

endmodule

// File: rtl/preset_down_counter.sv
// Top level: presettable 8-stage down counter, binary or two-decade mode.
// It wires the decrement network, the count register and the zero detect.
// All controls and the zero-detect output are active low.
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter count_mode_e MODE       = MODE_BINARY,
    parameter int          NUM_DIGITS = 2,
    localparam int         WIDTH      = NUM_DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_async_n,
    input  logic             load_sync_n,
    input  logic             cnt_en_n,
    input  logic [WIDTH-1:0] jam_word,
    output logic             zero_n,
    output logic [WIDTH-1:0] count_q
);

    localparam logic [WIDTH-1:0] MAX_CNT = WIDTH'(max_code(MODE, NUM_DIGITS));

    logic [WIDTH-1:0] next_val;

    pdc_step #(
        .MODE       (MODE),
        .NUM_DIGITS (NUM_DIGITS)
    ) u_step (
        .cur_i (count_q),
        .nxt_o (next_val)
    );

    pdc_state #(
        .WIDTH   (WIDTH),
        .MAX_CNT (MAX_CNT)
    ) u_state (
        .clk          (clk),
        .clear_n      (clear_n),
        .load_async_n (load_async_n),
        .load_sync_n  (load_sync_n),
        .cnt_en_n     (cnt_en_n),
        .jam_i        (jam_word),
        .nxt_i        (next_val),
        .count_o      (count_q)
    );

    pdc_zero #(
        .WIDTH (WIDTH)
    ) u_zero (
        .count_i  (count_q),
        .cnt_en_n (cnt_en_n),
        .zero_n   (zero_n)
    );

endmodule

// File: rtl/pdc_checker.sv
// Assertion checker bound to preset_down_counter. It watches only the ports.
module pdc_checker
    import pdc_pkg::*;
#(
    parameter count_mode_e MODE       = MODE_BINARY,
    parameter int          NUM_DIGITS = 2,
    localparam int         WIDTH      = NUM_DIGITS * DIGIT_W
) (
    input logic             clk,
    input logic             clear_n,
    input logic             load_async_n,
    input logic             load_sync_n,
    input logic             cnt_en_n,
    input logic [WIDTH-1:0] jam_word,
    input logic             zero_n,
    input logic [WIDTH-1:0] count_q
);

    localparam logic [WIDTH-1:0] MAX_CNT = WIDTH'(max_code(MODE, NUM_DIGITS));
    localparam logic             IS_BIN  = (MODE == MODE_BINARY);

    p_step_r2: assert property (@(posedge clk) disable iff (!clear_n || !load_async_n)
        (IS_BIN && load_sync_n && !cnt_en_n) |=> (count_q == WIDTH'($past(count_q) - 1'b1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!clear_n || !load_async_n)
        (load_sync_n && cnt_en_n) |=> $stable(count_q));

    p_sync_load_r4: assert property (@(posedge clk) disable iff (!clear_n || !load_async_n)
        (!load_sync_n) |=> (count_q == $past(jam_word)));

    p_async_load_r5: assert property (@(negedge clk) disable iff (!clear_n)
        (!load_async_n) |-> (count_q == jam_word));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!clear_n || !load_async_n)
        (!zero_n && load_sync_n) |=> (count_q == MAX_CNT && zero_n));

endmodule

bind preset_down_counter pdc_checker #(
    .MODE       (MODE),
    .NUM_DIGITS (NUM_DIGITS)
) u_pdc_checker (
    .clk          (clk),
    .clear_n      (clear_n),
    .load_async_n (load_async_n),
    .load_sync_n  (load_sync_n),
    .cnt_en_n     (cnt_en_n),
    .jam_word     (jam_word),
    .zero_n       (zero_n),
    .count_q      (count_q)
);

// File: tb/test_preset_down_counter.sv
// Bench: a binary and a decade instance share all inputs. Expected counts
// come from arithmetic models held in the bench.
module test_preset_down_counter;
    import pdc_pkg::*;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_async_n = 1'b1;
    logic       load_sync_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic [7:0] jam_word = 8'h00;
    logic       zn_b, zn_d;
    logic [7:0] cnt_b, cnt_d;
    logic [7:0] exp_b, exp_d;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    preset_down_counter #(.MODE(MODE_BINARY), .NUM_DIGITS(2)) i_preset_down_counter (
        .clk(clk), .clear_n(clear_n), .load_async_n(load_async_n),
        .load_sync_n(load_sync_n), .cnt_en_n(cnt_en_n), .jam_word(jam_word),
        .zero_n(zn_b), .count_q(cnt_b));

    preset_down_counter #(.MODE(MODE_DECADE), .NUM_DIGITS(2)) i_preset_down_counter_dec (
        .clk(clk), .clear_n(clear_n), .load_async_n(load_async_n),
        .load_sync_n(load_sync_n), .cnt_en_n(cnt_en_n), .jam_word(jam_word),
        .zero_n(zn_d), .count_q(cnt_d));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dec_next(input logic [7:0] v);
        int hi, lo, n;
        hi = int'(v[7:4]);
        lo = int'(v[3:0]);
        if (lo != 0) return {v[7:4], 4'(lo - 1)};
        if (hi > 9) return {4'(hi - 1), 4'd9};
        n = (hi * 10 + 99) % 100;
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check_zero(input string req);
        check(req, {7'd0, zn_b}, {7'd0, !((exp_b == 8'h00) && !cnt_en_n)});
        check(req, {7'd0, zn_d}, {7'd0, !((exp_d == 8'h00) && !cnt_en_n)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state through clear, with load_sync_n and cnt_en_n active
        load_sync_n = 1'b0;
        cnt_en_n = 1'b0;
        jam_word = 8'h42;
        #5;
        repeat (2) tick();
        check("R1", cnt_b, 8'hFF);
        check("R1", cnt_d, 8'h99);
        @(negedge clk);
        load_sync_n = 1'b1;
        cnt_en_n = 1'b1;
        clear_n = 1'b1;
        tick();
        check("R1", cnt_b, 8'hFF);
        check("R1", cnt_d, 8'h99);

        // R4 then R2/R9/R10/R7: load every jam value, then take one step
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            jam_word = 8'(v);
            load_sync_n = 1'b0;
            cnt_en_n = v[0];
            tick();
            check("R4", cnt_b, 8'(v));
            check("R4", cnt_d, 8'(v));
            exp_b = 8'(v);
            exp_d = 8'(v);
            @(negedge clk);
            load_sync_n = 1'b1;
            cnt_en_n = 1'b0;
            jam_word = ~8'(v);
            #1;
            check_zero("R7");
            tick();
            exp_b = exp_b - 8'd1;
            exp_d = dec_next(exp_d);
            check("R2", cnt_b, exp_b);
            if (v[3:0] > 4'd9 || v[7:4] > 4'd9) check("R10", cnt_d, exp_d);
            else check("R9", cnt_d, exp_d);
        end

        // R3 and R7: holding at a nonzero value and at zero
        foreach (exp_b[i]) begin end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            jam_word = (k == 0) ? 8'h57 : 8'h00;
            load_sync_n = 1'b0;
            tick();
            exp_b = jam_word;
            exp_d = jam_word;
            @(negedge clk);
            load_sync_n = 1'b1;
            cnt_en_n = 1'b1;
            for (int c = 0; c < 4; c++) begin
                jam_word = 8'(c * 37 + 5);
                tick();
                check("R3", cnt_b, exp_b);
                check("R3", cnt_d, exp_d);
                check_zero("R7");
            end
        end

        // R1 mid-cycle clear, then R8/R7 full free-running cycle
        @(negedge clk);
        clear_n = 1'b0;
        #1;
        check("R1", cnt_b, 8'hFF);
        check("R1", cnt_d, 8'h99);
        tick();
        @(negedge clk);
        clear_n = 1'b1;
        cnt_en_n = 1'b0;
        exp_b = 8'hFF;
        exp_d = 8'h99;
        for (int i = 1; i <= 256; i++) begin
            tick();
            exp_b = exp_b - 8'd1;
            exp_d = dec_next(exp_d);
            check("R8", cnt_b, exp_b);
            check("R8", cnt_d, exp_d);
            check_zero("R7");
            if (i == 100) check("R8", cnt_d, 8'h99);
            if (i == 256) check("R8", cnt_b, 8'hFF);
        end

        // R5/R6: asynchronous load, its override, and clear priority
        for (int k = 0; k < 4; k++) begin
            logic [7:0] val;
            val = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h3A : 8'h99;
            @(negedge clk);
            jam_word = val;
            load_async_n = 1'b0;
            load_sync_n = k[0];
            cnt_en_n = 1'b0;
            #1;
            check("R5", cnt_b, val);
            check("R5", cnt_d, val);
            tick();
            check("R5", cnt_b, val);
            check("R5", cnt_d, val);
            @(negedge clk);
            clear_n = 1'b0;
            #1;
            check("R6", cnt_b, 8'hFF);
            check("R6", cnt_d, 8'h99);
            tick();
            check("R6", cnt_b, 8'hFF);
            check("R6", cnt_d, 8'h99);
            @(negedge clk);
            load_async_n = 1'b1;
            load_sync_n = 1'b1;
            cnt_en_n = 1'b1;
            #2;
            clear_n = 1'b1;
            tick();
            check("R1", cnt_b, 8'hFF);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule